// File: doc/BRIEF.md
# Debug Breakpoint and Control Unit

This unit is the register-level part of an on-chip debugger for a small 8-bit processor. A serial debug port that sits outside the unit reaches a control register and a read-only status register over a narrow register bus. The processor core reports each decoded opcode to the unit. An opcode of 0x00 is the break instruction. It either passes as a no-op or forces the core into debug mode, depending on a break-enable bit.

When acknowledgement is enabled, each break event and each watchpoint hit (signalled from outside) queues the byte 0xFF for the host. The unit offers that byte on a valid/ready byte stream. A control bit also lets the host reset the rest of the device. The unit then drives a fixed-length reset pulse, and its own registers are not affected. The reset bit reads back as 1 until the device reports that its reset has finished.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: After `rst_n` is released, the control register reads 0x00, the status register reads 0x00 while `core_halted` and `core_flag` are low, `tx_valid` is 0 and `dev_rst` is 0.
- R2: `bus_addr`=0 selects control and `bus_addr`=1 selects status. Reads are combinational and writes take effect at the clock edge. The control fields are: bit 7 debug mode, bit 6 break enable, bit 5 acknowledge enable, bit 0 device reset. Bits 4..1 always read 0, whatever was written to them.
- R3: While break enable is 0, an opcode of 0x00 with `op_valid` changes neither `dbg_mode` nor any control bit.
- R4: While break enable is 1, `op_valid` with opcode 0x00 sets the debug-mode bit (`dbg_mode`) at the next edge. Any other opcode leaves it unchanged.
- R5: Writing 0 to control bit 7 returns `dbg_mode` to 0. If a break event happens in the same cycle as that write, debug mode stays at 1.
- R6: Status bit 7 mirrors `dbg_mode`, bit 6 mirrors `core_halted` and bit 5 mirrors `core_flag`. Bits 4..0 read 0. Writes to the status address change nothing.
- R7: While acknowledge enable is 1, each break event and each `wp_hit` cycle queues one byte. `tx_valid` rises in the cycle after the event, with `tx_data`=0xFF. It stays high until a cycle with `tx_ready` high accepts the byte. While acknowledge enable is 0, no byte is queued.
- R8: At most `ACK_DEPTH` bytes wait at once, and further events are dropped. Each accepted transfer removes exactly one byte.
- R9: Writing 1 to control bit 0 raises `dev_rst` from the next cycle for exactly `RST_CYCLES` cycles. Bit 0 reads 1 until `dev_rst_done` is seen after the pulse has ended. `dev_rst_done` seen during the pulse is ignored. A second write of 1 while busy does not restart the pulse. Writing 0 to bit 0 has no effect.
- R10: A device reset leaves the break-enable, acknowledge-enable and debug-mode settings unchanged, and break handling keeps working afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the debug unit itself |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| op_valid | input | 1 | A decoded opcode is presented |
| op_code | input | 8 | Decoded opcode |
| wp_hit | input | 1 | Watchpoint event from external matcher |
| core_halted | input | 1 | Core is in halt mode |
| core_flag | input | 1 | Extra core status flag for status bit 5 |
| dbg_mode | output | 1 | Core is held in debug mode |
| dev_rst | output | 1 | Device reset pulse |
| dev_rst_done | input | 1 | Device reset sequence has finished |
| tx_valid | output | 1 | Acknowledge byte offered to host link |
| tx_ready | input | 1 | Host link accepts the byte |
| tx_data | output | 8 | Acknowledge byte (0xFF) |

## Verification
A wrong debug-mode flop appears at `dbg_mode` and in status bit 7 in the cycle after the faulty break or write. That includes losing the case where a break and a clearing write fall in the same cycle. A miscounted acknowledge queue shows as `tx_valid` staying high or dropping out early during a burst of accepts, so the scoreboard sees too many or too few 0xFF bytes. A wrong reset counter changes the measured width of `dev_rst` at once. A busy flag that clears too early shows when control bit 0 is read back after an early `dev_rst_done`.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

  localparam logic [7:0] BRK_OPCODE = 8'h00;
  localparam logic [7:0] ACK_BYTE   = 8'hFF;

  localparam int CTL_DBG   = 7;
  localparam int CTL_BRKEN = 6;
  localparam int CTL_ACKEN = 5;
  localparam int CTL_RST   = 0;

  localparam int STS_DBG  = 7;
  localparam int STS_HALT = 6;
  localparam int STS_AUX  = 5;

  typedef struct packed {
    logic dbg;
    logic brk_en;
    logic ack_en;
  } ctl_t;

  function automatic logic is_break(logic valid, logic [7:0] op, logic en);
    return valid && en && (op == BRK_OPCODE);
  endfunction

  function automatic logic [7:0] pack_ctl(ctl_t c, logic rst_busy);
    logic [7:0] v;
    v = '0;
    v[CTL_DBG]   = c.dbg;
    v[CTL_BRKEN] = c.brk_en;
    v[CTL_ACKEN] = c.ack_en;
    v[CTL_RST]   = rst_busy;
    return v;
  endfunction

  function automatic logic [7:0] pack_sts(logic dbg, logic halt, logic aux);
    logic [7:0] v;
    v = '0;
    v[STS_DBG]  = dbg;
    v[STS_HALT] = halt;
    v[STS_AUX]  = aux;
    return v;
  endfunction

  function automatic int unsigned ack_step(int unsigned cnt, logic push,
                                           logic pop, int unsigned depth);
    if (push && !pop) return (cnt < depth) ? cnt + 1 : cnt;
    if (pop && !push) return (cnt > 0) ? cnt - 1 : 0;
    return cnt;
  endfunction

endpackage

// File: rtl/dbgc_ctlreg.sv
module dbgc_ctlreg
  import dbgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       brk_evt,
  output ctl_t       ctl
);

  ctl_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q.brk_en <= wdata[CTL_BRKEN];
      q.ack_en <= wdata[CTL_ACKEN];
      q.dbg    <= wdata[CTL_DBG] | brk_evt;
    end else if (brk_evt) begin
      q.dbg <= 1'b1;
    end
  end

  assign ctl = q;

  assert_brk_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> q.dbg);
  assert_clear_dbg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[CTL_DBG] && !brk_evt) |=> !q.dbg);

endmodule

// File: rtl/dbgc_ackq.sv
module dbgc_ackq
  import dbgc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          pop;

  assign tx_valid = (cnt_q != '0);
  assign tx_data  = tx_valid ? ACK_BYTE : 8'h00;
  assign pop      = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(ack_step(32'(cnt_q), push, pop, DEPTH));
  end

  assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  assert_push_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !tx_valid) |=> (tx_valid && tx_data == ACK_BYTE));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid);

endmodule

// File: rtl/dbgc_rstgen.sv
module dbgc_rstgen #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic done,
  output logic dev_rst,
  output logic busy
);

  localparam int RW = $clog2(CYCLES + 1);
  localparam logic [RW-1:0] CYC_C = RW'(CYCLES);

  logic [RW-1:0] cnt_q;
  logic          busy_q;
  logic          start;
  logic [RW:0]   hi_run;

  assign start   = start_req && !busy_q;
  assign dev_rst = (cnt_q != '0);
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CYC_C;
      busy_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (busy_q && cnt_q == '0 && done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (dev_rst) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;
  end

  assert_pulse_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |-> busy_q);
  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_rst) |-> (hi_run == (RW+1)'(CYCLES)));
  assert_busy_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done));

endmodule

// File: rtl/dbg_ctrl_unit.sv
module dbg_ctrl_unit
  import dbgc_pkg::*;
#(
  parameter int ACK_DEPTH  = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       wp_hit,
  input  logic       core_halted,
  input  logic       core_flag,
  output logic       dbg_mode,
  output logic       dev_rst,
  input  logic       dev_rst_done,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);

  ctl_t ctl;
  logic ctl_wr;
  logic brk_evt;
  logic ack_push;
  logic rst_busy;
  logic unused_rsvd;

  assign ctl_wr      = bus_wr && !bus_addr;
  assign brk_evt     = is_break(op_valid, op_code, ctl.brk_en);
  assign ack_push    = ctl.ack_en && (brk_evt || wp_hit);
  assign dbg_mode    = ctl.dbg;
  assign unused_rsvd = ^bus_wdata[4:1];

  dbgc_ctlreg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr),
    .wdata   (bus_wdata),
    .brk_evt (brk_evt),
    .ctl     (ctl)
  );

  dbgc_ackq #(.DEPTH(ACK_DEPTH)) u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_push),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  dbgc_rstgen #(.CYCLES(RST_CYCLES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (ctl_wr && bus_wdata[CTL_RST]),
    .done      (dev_rst_done),
    .dev_rst   (dev_rst),
    .busy      (rst_busy)
  );

  always_comb begin
    if (bus_addr) bus_rdata = pack_sts(ctl.dbg, core_halted, core_flag);
    else          bus_rdata = pack_ctl(ctl, rst_busy);
  end

  assert_nop_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.brk_en && !ctl_wr) |=> $stable(dbg_mode));
  assert_brk_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == BRK_OPCODE && ctl.brk_en) |=> dbg_mode);
  assert_status_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> (bus_rdata[4:0] == 5'd0 && bus_rdata[7] == dbg_mode &&
                  bus_rdata[6] == core_halted && bus_rdata[5] == core_flag));
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> (bus_rdata[4:1] == 4'd0));
  assert_ctl_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst && !ctl_wr) |=> $stable(ctl.brk_en) && $stable(ctl.ack_en));

endmodule

// File: tb/sim_dbg_ctrl_unit.sv
module sim_dbg_ctrl_unit;

  localparam int DEPTH = 4;
  localparam int RCYC  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h55;
  logic       wp_hit = 1'b0, core_halted = 1'b0, core_flag = 1'b0;
  logic       dbg_mode, dev_rst, dev_rst_done = 1'b0;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;

  int checks = 0, errors = 0, popped = 0, mcount = 0;
  bit ackon = 0, brkon = 0, done_flag = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  dbg_ctrl_unit #(.ACK_DEPTH(DEPTH), .RST_CYCLES(RCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_valid(op_valid),
    .op_code(op_code), .wp_hit(wp_hit), .core_halted(core_halted),
    .core_flag(core_flag), .dbg_mode(dbg_mode), .dev_rst(dev_rst),
    .dev_rst_done(dev_rst_done), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on each accepted transfer
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      popped++;
      if (mcount > 0) mcount--;
      if (exp_q.size() == 0) chk("R7 unexpected byte", tx_data, 8'hxx);
      else chk("R7 scoreboard", tx_data, exp_q.pop_front());
    end
  end

  function automatic void expect_push();
    if (ackon && mcount < DEPTH) begin
      mcount++;
      exp_q.push_back(8'hFF);
    end
  endfunction

  task automatic wr(logic a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (!a) begin brkon = d[6]; ackon = d[5]; end
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata; bus_addr = 1'b0;
  endtask

  task automatic brk(logic [7:0] op);
    op_valid = 1'b1; op_code = op;
    if (op == 8'h00 && brkon) expect_push();
    @(negedge clk);
    op_valid = 1'b0; op_code = 8'h55;
  endtask

  task automatic wp();
    wp_hit = 1'b1; expect_push();
    @(negedge clk);
    wp_hit = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 status", v, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
    chk("R1 dev_rst", {7'd0, dev_rst}, 8'd0);
    // R2 reserved bits
    wr(0, 8'h1E);
    rd(0, v); chk("R2 reserved read 0", v, 8'h00);
    chk("R2 no reset", {7'd0, dev_rst}, 8'd0);
    // R3 break disabled
    brk(8'h00);
    chk("R3 dbg stays 0", {7'd0, dbg_mode}, 8'd0);
    rd(0, v); chk("R3 ctrl unchanged", v, 8'h00);
    // R4 break enabled
    wr(0, 8'h40);
    brk(8'h12);
    chk("R4 other opcode", {7'd0, dbg_mode}, 8'd0);
    brk(8'h00);
    chk("R4 break sets dbg", {7'd0, dbg_mode}, 8'd1);
    rd(0, v); chk("R4 ctrl readback", v, 8'hC0);
    // R6 status
    rd(1, v); chk("R6 status dbg", v, 8'h80);
    core_halted = 1'b1; core_flag = 1'b1;
    rd(1, v); chk("R6 status all", v, 8'hE0);
    wr(1, 8'h00);
    rd(0, v); chk("R6 status write ignored", v, 8'hC0);
    core_halted = 1'b0; core_flag = 1'b0;
    // R5 clear and collision
    wr(0, 8'h40);
    chk("R5 clear dbg", {7'd0, dbg_mode}, 8'd0);
    brk(8'h00);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h40;
    op_valid = 1'b1; op_code = 8'h00;
    @(negedge clk);
    bus_wr = 1'b0; op_valid = 1'b0; op_code = 8'h55;
    chk("R5 break wins", {7'd0, dbg_mode}, 8'd1);
    // R7 acknowledge queue
    tx_ready = 1'b0;
    wr(0, 8'h60);
    brk(8'h00);
    chk("R7 tx_valid", {7'd0, tx_valid}, 8'd1);
    chk("R7 tx_data", tx_data, 8'hFF);
    repeat (3) @(negedge clk);
    chk("R7 held without ready", {7'd0, tx_valid}, 8'd1);
    wp();
    repeat (4) brk(8'h00);
    // R8 only DEPTH accepted
    tx_ready = 1'b1;
    repeat (8) @(negedge clk);
    tx_ready = 1'b0;
    chk("R8 bytes delivered", 8'(popped), 8'(DEPTH));
    chk("R8 queue empty", {7'd0, tx_valid}, 8'd0);
    wr(0, 8'h40);
    brk(8'h00); wp();
    chk("R7 ack disabled", {7'd0, tx_valid}, 8'd0);
    // R9 device reset
    wr(0, 8'h41);
    hi = 0;
    for (int i = 0; i < 14; i++) begin
      dev_rst_done = (i == 3);
      if (dev_rst) hi++;
      if (i == 5) begin
        bus_wr = 1'b1; bus_wdata = 8'h41;
      end else bus_wr = 1'b0;
      @(negedge clk);
    end
    dev_rst_done = 1'b0;
    chk("R9 pulse width", 8'(hi), 8'(RCYC));
    rd(0, v); chk("R9 busy until done", v, 8'h41);
    dev_rst_done = 1'b1;
    @(negedge clk);
    dev_rst_done = 1'b0;
    rd(0, v); chk("R9 cleared by done / R10 kept", v, 8'h40);
    wr(0, 8'h40);
    repeat (2) @(negedge clk);
    chk("R9 write 0 no pulse", {7'd0, dev_rst}, 8'd0);
    brk(8'h00);
    chk("R10 break after reset", {7'd0, dbg_mode}, 8'd1);
    chk("R7 scoreboard drained", 8'(exp_q.size()), 8'd0);
    summary();
  end

endmodule